// File: doc/BRIEF.md
# DMA Handshake FIFO Port

This block is the side door through which an external DMA controller moves data in and out of one endpoint packet buffer. It raises a request line toward the controller when the buffer can be served and turns the controller's acknowledge, read, write and terminal-count strobes into single-cycle read and write enables for the buffer. The enables are synchronous to the block clock. The packet engine and the buffer memory sit outside. They supply a ready flag, a valid flag, the endpoint direction and the current fill level. They receive the enables, the write data, a commit pulse for a short packet and two pointer-clear pulses.

A six-bit control field configures the port. It selects one of three strobe-decoding schemes, chooses a request that covers one transfer or a request that covers the whole buffer, and sets the active level of the acknowledge input and of the request output. The same field also carries a self-clearing rewind command. All strobes arrive asynchronously and pass through synchronizers. Each enable therefore appears a fixed three clock cycles after the strobe edge that causes it.

Top module: `dma_fifo_port`

## Requirements
- R1: With control bit 5 = 0 (per-transfer request), the request is active while the buffer is ready and no access window is open. It goes inactive within 3 cycles of an acknowledge (or, in mode 10, a select plus strobe) and returns once the window closes.
- R2: With control bit 5 = 1 (whole-buffer request), the request goes active on a rising edge of the ready flag and stays active through accesses. It drops when the fill level reaches 0 for an OUT endpoint, or BUF_WORDS for an IN endpoint, or when ready falls. It stays inactive until ready rises again.
- R3: Mode 00 (control bits 4:3): a read starts when acknowledge and RD are both active. A write completes when WR returns high while acknowledge is still active.
- R4: Mode 01: RD and WR are ignored. The acknowledge window is a read for an OUT endpoint. For an IN endpoint it is a write that completes when acknowledge ends.
- R5: Mode 10: acknowledge is ignored and the select input qualifies the access. A read starts when select and RD are active. A write completes when WR returns high while select is active.
- R6: Mode 11 produces no buffer enable for any strobe pattern.
- R7: With direction 0 (OUT), writes produce no write enable. With direction 1 (IN), reads produce no read enable and the read-data output becomes 0.
- R8: A write completed while TC (active high) is held produces a commit pulse together with its write enable, and ends a whole-buffer request.
- R9: Writing 1 to control bit 2 pulses rd_ptr_clr for one cycle when buf_valid = 1, or wr_ptr_clr when buf_valid = 0. Bit 2 always reads back as 0.
- R10: Control bit 1 = 1 makes acknowledge active high (0: active low). Control bit 0 = 1 makes the request output active high (0: active low).
- R11: Each access yields exactly one single-cycle enable. Write data is the data bus value held during the write strobe. Read data is the buffer word fetched one cycle after the read enable.
- R12: After reset the control field reads 0, the request output is high (inactive, active-low default), and no enable, commit or clear pulse is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_we | input | 1 | Control field write strobe |
| ctrl_wdata | input | 6 | Control write data: 5 request style, 4:3 mode, 2 rewind, 1 acknowledge level, 0 request level |
| ctrl_rdata | output | 6 | Control read-back, rewind bit reads 0 |
| ep_is_in | input | 1 | Endpoint direction, 1 = IN (host reads), 0 = OUT |
| buf_ready | input | 1 | Buffer can be accessed from the DMA side |
| buf_valid | input | 1 | Buffer holds valid data, steers the rewind target |
| fill_level | input | LEVEL_W | Words currently in the buffer |
| dma_dack | input | 1 | DMA acknowledge, asynchronous |
| dma_rd_n | input | 1 | DMA read strobe, active low, asynchronous |
| dma_wr_n | input | 1 | DMA write strobe, active low, asynchronous |
| dma_sel | input | 1 | Address-decode select, active high, asynchronous |
| dma_tc | input | 1 | Terminal count, active high, asynchronous |
| dma_wdata | input | DATA_W | DMA write data bus |
| dma_rdata | output | DATA_W | DMA read data |
| dma_dreq | output | 1 | DMA request, level set by control bit 0 |
| buf_rd_en | output | 1 | One-cycle buffer read enable |
| buf_rdata | input | DATA_W | Buffer word, valid the cycle after buf_rd_en |
| buf_wr_en | output | 1 | One-cycle buffer write enable |
| buf_wdata | output | DATA_W | Buffer write data |
| buf_commit | output | 1 | Short-packet commit pulse |
| rd_ptr_clr | output | 1 | Buffer read pointer clear pulse |
| wr_ptr_clr | output | 1 | Buffer write pointer clear pulse |

## Verification
A wrong edge or level register in the decoder shows at the buffer interface as a missing, doubled or misplaced enable. This is visible three cycles after the offending strobe edge. A corrupt request state shows on dma_dreq within one cycle of the access window or level change that should have moved it. A stuck whole-buffer state shows as a request that never drops at the empty or full boundary, or never returns after ready is toggled. Direction or mode mistakes surface as enables where none may appear, and the scoreboard treats every unexpected enable as an error.

// File: rtl/dma_port_pkg.sv
`timescale 1ns/1ps
// dma_port_pkg: shared control-field layout and types for the DMA port.
// Assumes a six-bit control field; positions are fixed because the
// software view decodes them.
package dma_port_pkg;
    localparam int CTRL_W      = 6;
    localparam int BIT_BURST   = 5;
    localparam int BIT_MODE_HI = 4;
    localparam int BIT_MODE_LO = 3;
    localparam int BIT_REWIND  = 2;
    localparam int BIT_ACK_POL = 1;
    localparam int BIT_REQ_POL = 0;

    typedef enum logic [1:0] {
        XFER_RDWR    = 2'b00,
        XFER_ACKONLY = 2'b01,
        XFER_SELECT  = 2'b10,
        XFER_NONE    = 2'b11
    } xfer_mode_e;

    typedef struct packed {
        logic       burst;
        xfer_mode_e mode;
        logic       ack_pol;
        logic       req_pol;
    } port_cfg_t;
endpackage

// File: rtl/dma_port_sync.sv
`timescale 1ns/1ps
// dma_port_sync: multi-stage synchronizer for a bundle of async strobes.
// Assumes each bit is an independent level; STAGES must be at least 2.
module dma_port_sync #(
    parameter int               WIDTH     = 5,
    parameter int               STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    // Shift the raw inputs through the synchronizer stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= {STAGES{RESET_VAL}};
        end else begin
            stage_q <= {stage_q[STAGES-2:0], async_i};
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/dma_port_decode.sv
`timescale 1ns/1ps
// dma_port_decode: turns synchronized strobes into read-start and
// write-done pulses for the selected decoding mode.
// Assumes inputs are already synchronized; the pulses are combinational
// and last one cycle because they come from level edges.
module dma_port_decode
    import dma_port_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  xfer_mode_e mode,
    input  logic       ack_pol,
    input  logic       ep_is_in,
    input  logic       dack_s,
    input  logic       rd_n_s,
    input  logic       wr_n_s,
    input  logic       sel_s,
    output logic       rd_start,
    output logic       wr_done,
    output logic       wr_strobe,
    output logic       window
);
    logic ack_act;
    logic rd_act;
    logic wr_act;
    logic rd_lvl;
    logic wr_lvl;
    logic rd_lvl_q;
    logic wr_lvl_q;

    assign ack_act = ack_pol ? dack_s : ~dack_s;
    assign rd_act  = ~rd_n_s;
    assign wr_act  = ~wr_n_s;

    // Form the read and write access levels for the active mode.
    always_comb begin
        rd_lvl = 1'b0;
        wr_lvl = 1'b0;
        window = 1'b0;
        case (mode)
            XFER_RDWR: begin
                rd_lvl = ack_act & rd_act;
                wr_lvl = ack_act & wr_act;
                window = ack_act;
            end
            XFER_ACKONLY: begin
                rd_lvl = ack_act & ~ep_is_in;
                wr_lvl = ack_act & ep_is_in;
                window = ack_act;
            end
            XFER_SELECT: begin
                rd_lvl = sel_s & rd_act;
                wr_lvl = sel_s & wr_act;
                window = sel_s & (rd_act | wr_act);
            end
            default: begin
                rd_lvl = 1'b0;
                wr_lvl = 1'b0;
                window = 1'b0;
            end
        endcase
    end

    // Remember last cycle's levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_lvl_q <= 1'b0;
            wr_lvl_q <= 1'b0;
        end else begin
            rd_lvl_q <= rd_lvl;
            wr_lvl_q <= wr_lvl;
        end
    end

    assign rd_start  = rd_lvl & ~rd_lvl_q;
    assign wr_done   = wr_lvl_q & ~wr_lvl;
    assign wr_strobe = wr_lvl;
endmodule

// File: rtl/dma_port_dreq.sv
`timescale 1ns/1ps
// dma_port_dreq: request generator with per-transfer and whole-buffer
// styles plus output polarity. Assumes fill_level counts words and that a
// whole-buffer request is armed only by a rising ready flag.
module dma_port_dreq #(
    parameter int LEVEL_W   = 10,
    parameter int BUF_WORDS = 512
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               burst,
    input  logic               req_pol,
    input  logic               buf_ready,
    input  logic               ep_is_in,
    input  logic [LEVEL_W-1:0] fill_level,
    input  logic               window,
    input  logic               close,
    output logic               dreq
);
    localparam logic [LEVEL_W-1:0] FULL_LVL = LEVEL_W'(BUF_WORDS);

    logic boundary;
    logic ready_q;
    logic burst_on;
    logic req_d;
    logic req_q;

    assign boundary = ep_is_in ? (fill_level >= FULL_LVL) : (fill_level == '0);

    // Track ready edges and the whole-buffer request state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready_q  <= 1'b0;
            burst_on <= 1'b0;
        end else begin
            ready_q <= buf_ready;
            if (!buf_ready || boundary || close) begin
                burst_on <= 1'b0;
            end else if (!ready_q) begin
                burst_on <= 1'b1;
            end
        end
    end

    assign req_d = burst ? burst_on : (buf_ready & ~window);

    // Register the internal request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
        end else begin
            req_q <= req_d;
        end
    end

    assign dreq = req_pol ? req_q : ~req_q;
endmodule

// File: rtl/dma_fifo_port.sv
`timescale 1ns/1ps
// dma_fifo_port: DMA-side access port to one endpoint packet buffer.
// Assumes buf_rdata is valid the cycle after buf_rd_en and that the DMA
// data bus is stable while its write strobe is active and for three
// cycles after.
module dma_fifo_port
    import dma_port_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int LEVEL_W     = 10,
    parameter int BUF_WORDS   = 512,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctrl_we,
    input  logic [CTRL_W-1:0]  ctrl_wdata,
    output logic [CTRL_W-1:0]  ctrl_rdata,
    input  logic               ep_is_in,
    input  logic               buf_ready,
    input  logic               buf_valid,
    input  logic [LEVEL_W-1:0] fill_level,
    input  logic               dma_dack,
    input  logic               dma_rd_n,
    input  logic               dma_wr_n,
    input  logic               dma_sel,
    input  logic               dma_tc,
    input  logic [DATA_W-1:0]  dma_wdata,
    output logic [DATA_W-1:0]  dma_rdata,
    output logic               dma_dreq,
    output logic               buf_rd_en,
    input  logic [DATA_W-1:0]  buf_rdata,
    output logic               buf_wr_en,
    output logic [DATA_W-1:0]  buf_wdata,
    output logic               buf_commit,
    output logic               rd_ptr_clr,
    output logic               wr_ptr_clr
);
    localparam int               N_STROBES  = 5;
    localparam logic [N_STROBES-1:0] STROBE_IDLE = 5'b00111;

    port_cfg_t             cfg_q;
    logic [N_STROBES-1:0]  strobes_s;
    logic                  dack_s, rd_n_s, wr_n_s, tc_s, sel_s;
    logic                  rd_start, wr_done, wr_strobe, window;
    logic                  rd_cap_q;
    logic [DATA_W-1:0]     rdata_q;
    logic [DATA_W-1:0]     wdata_q;

    // Hold the configuration fields; rewind is not stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (ctrl_we) begin
            cfg_q.burst   <= ctrl_wdata[BIT_BURST];
            cfg_q.mode    <= xfer_mode_e'(ctrl_wdata[BIT_MODE_HI:BIT_MODE_LO]);
            cfg_q.ack_pol <= ctrl_wdata[BIT_ACK_POL];
            cfg_q.req_pol <= ctrl_wdata[BIT_REQ_POL];
        end
    end

    // Assemble the read-back value with rewind forced to zero.
    always_comb begin
        ctrl_rdata                          = '0;
        ctrl_rdata[BIT_BURST]               = cfg_q.burst;
        ctrl_rdata[BIT_MODE_HI:BIT_MODE_LO] = cfg_q.mode;
        ctrl_rdata[BIT_ACK_POL]             = cfg_q.ack_pol;
        ctrl_rdata[BIT_REQ_POL]             = cfg_q.req_pol;
    end

    // Issue one-cycle pointer clears, steered by the valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr_clr <= 1'b0;
            wr_ptr_clr <= 1'b0;
        end else begin
            rd_ptr_clr <= ctrl_we & ctrl_wdata[BIT_REWIND] & buf_valid;
            wr_ptr_clr <= ctrl_we & ctrl_wdata[BIT_REWIND] & ~buf_valid;
        end
    end

    dma_port_sync #(
        .WIDTH     (N_STROBES),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (STROBE_IDLE)
    ) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({dma_sel, dma_tc, dma_wr_n, dma_rd_n, dma_dack}),
        .sync_o  (strobes_s)
    );

    assign {sel_s, tc_s, wr_n_s, rd_n_s, dack_s} = strobes_s;

    dma_port_decode decode_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (cfg_q.mode),
        .ack_pol   (cfg_q.ack_pol),
        .ep_is_in  (ep_is_in),
        .dack_s    (dack_s),
        .rd_n_s    (rd_n_s),
        .wr_n_s    (wr_n_s),
        .sel_s     (sel_s),
        .rd_start  (rd_start),
        .wr_done   (wr_done),
        .wr_strobe (wr_strobe),
        .window    (window)
    );

    // Gate access pulses by direction and register the buffer strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_rd_en  <= 1'b0;
            buf_wr_en  <= 1'b0;
            buf_commit <= 1'b0;
            rd_cap_q   <= 1'b0;
        end else begin
            buf_rd_en  <= rd_start & ~ep_is_in;
            buf_wr_en  <= wr_done & ep_is_in;
            buf_commit <= wr_done & ep_is_in & tc_s;
            rd_cap_q   <= buf_rd_en;
        end
    end

    // Latch the fetched word; blocked reads return zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_start && ep_is_in) begin
            rdata_q <= '0;
        end else if (rd_cap_q) begin
            rdata_q <= buf_rdata;
        end
    end

    // Sample the DMA data bus while the write strobe is active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wdata_q <= '0;
        end else if (wr_strobe) begin
            wdata_q <= dma_wdata;
        end
    end

    assign dma_rdata = rdata_q;
    assign buf_wdata = wdata_q;

    dma_port_dreq #(
        .LEVEL_W   (LEVEL_W),
        .BUF_WORDS (BUF_WORDS)
    ) dreq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .burst      (cfg_q.burst),
        .req_pol    (cfg_q.req_pol),
        .buf_ready  (buf_ready),
        .ep_is_in   (ep_is_in),
        .fill_level (fill_level),
        .window     (window),
        .close      (buf_commit),
        .dreq       (dma_dreq)
    );
endmodule

// File: rtl/dma_fifo_port_chk.sv
`timescale 1ns/1ps
// dma_fifo_port_chk: port-level properties of the DMA port, bound to the
// top. Assumes the control field layout from dma_port_pkg.
module dma_fifo_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [5:0] ctrl_rdata,
    input logic       ep_is_in,
    input logic       buf_valid,
    input logic       buf_rd_en,
    input logic       buf_wr_en,
    input logic       buf_commit,
    input logic       rd_ptr_clr,
    input logic       wr_ptr_clr,
    input logic       dma_dreq
);
    p_steal_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_rd_en && !ctrl_rdata[5] && $stable(ctrl_rdata)) |-> (dma_dreq != ctrl_rdata[0]));

    p_reserved_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ctrl_rdata[4:3]) == 2'b11) |-> !(buf_rd_en || buf_wr_en));

    p_wr_dir_r7: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr_en |-> $past(ep_is_in));

    p_rd_dir_r7: assert property (@(posedge clk) disable iff (!rst_n)
        buf_rd_en |-> !$past(ep_is_in));

    p_commit_with_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        buf_commit |-> buf_wr_en);

    p_rewind_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ptr_clr |-> ($past(buf_valid) && !wr_ptr_clr));

    p_rewind_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ptr_clr |-> !$past(buf_valid));

    p_single_wr_r11: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr_en |=> !buf_wr_en);

    p_single_rd_r11: assert property (@(posedge clk) disable iff (!rst_n)
        buf_rd_en |=> !buf_rd_en);
endmodule

bind dma_fifo_port dma_fifo_port_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_rdata (ctrl_rdata),
    .ep_is_in   (ep_is_in),
    .buf_valid  (buf_valid),
    .buf_rd_en  (buf_rd_en),
    .buf_wr_en  (buf_wr_en),
    .buf_commit (buf_commit),
    .rd_ptr_clr (rd_ptr_clr),
    .wr_ptr_clr (wr_ptr_clr),
    .dma_dreq   (dma_dreq)
);

// File: tb/dma_fifo_port_tb_top.sv
`timescale 1ns/1ps
// dma_fifo_port_tb_top: scoreboard bench. Driver tasks queue the buffer
// strobes each access should cause; a monitor pops and compares them.
module dma_fifo_port_tb_top;
    localparam int DATA_W = 16, LEVEL_W = 10, BUF_WORDS = 512;
    localparam int K_RD = 0, K_WR = 1, K_WRC = 2, K_RCLR = 3, K_WCLR = 4, K_STRAY = 5;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               ctrl_we = 1'b0;
    logic [5:0]         ctrl_wdata = '0;
    logic [5:0]         ctrl_rdata;
    logic               ep_is_in = 1'b0;
    logic               buf_ready = 1'b0;
    logic               buf_valid = 1'b0;
    logic [LEVEL_W-1:0] fill_level = '0;
    logic               dma_dack = 1'b1;
    logic               dma_rd_n = 1'b1;
    logic               dma_wr_n = 1'b1;
    logic               dma_sel = 1'b0;
    logic               dma_tc = 1'b0;
    logic [DATA_W-1:0]  dma_wdata = '0;
    logic [DATA_W-1:0]  dma_rdata;
    logic               dma_dreq;
    logic               buf_rd_en;
    logic [DATA_W-1:0]  mem_word = '0;
    logic               buf_wr_en;
    logic [DATA_W-1:0]  buf_wdata;
    logic               buf_commit;
    logic               rd_ptr_clr;
    logic               wr_ptr_clr;

    int checks = 0;
    int errors = 0;
    int rd_seen = 0;
    int wr_seen = 0;
    bit ack_pol_b = 1'b0;
    bit req_pol_b = 1'b0;
    bit done_flag = 1'b0;
    int          q_kind[$];
    logic [15:0] q_data[$];
    string       q_tag[$];

    always #2.5 clk = ~clk;

    dma_fifo_port #(
        .DATA_W (DATA_W), .LEVEL_W (LEVEL_W), .BUF_WORDS (BUF_WORDS), .SYNC_STAGES (2)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .ctrl_we (ctrl_we), .ctrl_wdata (ctrl_wdata),
        .ctrl_rdata (ctrl_rdata), .ep_is_in (ep_is_in), .buf_ready (buf_ready),
        .buf_valid (buf_valid), .fill_level (fill_level), .dma_dack (dma_dack),
        .dma_rd_n (dma_rd_n), .dma_wr_n (dma_wr_n), .dma_sel (dma_sel), .dma_tc (dma_tc),
        .dma_wdata (dma_wdata), .dma_rdata (dma_rdata), .dma_dreq (dma_dreq),
        .buf_rd_en (buf_rd_en), .buf_rdata (mem_word), .buf_wr_en (buf_wr_en),
        .buf_wdata (buf_wdata), .buf_commit (buf_commit), .rd_ptr_clr (rd_ptr_clr),
        .wr_ptr_clr (wr_ptr_clr)
    );

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic expect_item(int k, logic [15:0] d, string tag);
        q_kind.push_back(k);
        q_data.push_back(d);
        q_tag.push_back(tag);
    endtask

    task automatic observe(int k, logic [15:0] d);
        int ek;
        logic [15:0] ed;
        string t;
        if (q_kind.size() == 0) begin
            check(1'b0, "R11 unexpected buffer strobe", {k[15:0], d}, 32'hFFFF_FFFF);
        end else begin
            ek = q_kind.pop_front();
            ed = q_data.pop_front();
            t  = q_tag.pop_front();
            check(k == ek && ((k != K_WR && k != K_WRC) || d == ed), t,
                  {k[15:0], d}, {ek[15:0], ed});
        end
    endtask

    // Monitor: compare every buffer-side pulse with the scoreboard.
    always @(negedge clk) begin
        if (rst_n && !done_flag) begin
            if (buf_wr_en) begin
                wr_seen++;
                observe(buf_commit ? K_WRC : K_WR, buf_wdata);
            end else if (buf_commit) begin
                observe(K_STRAY, '0);
            end
            if (buf_rd_en) begin
                rd_seen++;
                observe(K_RD, '0);
            end
            if (rd_ptr_clr) observe(K_RCLR, '0);
            if (wr_ptr_clr) observe(K_WCLR, '0);
        end
    end

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    function automatic logic dack_lvl(bit act);
        return ack_pol_b ? act : !act;
    endfunction

    function automatic logic dreq_lvl(bit act);
        return req_pol_b ? act : !act;
    endfunction

    task automatic set_ctrl(bit burst, bit [1:0] mode, bit rew, bit ap, bit rp);
        ctrl_wdata = {burst, mode, rew, ap, rp};
        ctrl_we = 1'b1;
        if (rew) expect_item(buf_valid ? K_RCLR : K_WCLR, '0, "R9 rewind target");
        tick(1);
        ctrl_we = 1'b0;
        ack_pol_b = ap;
        req_pol_b = rp;
        dma_dack = dack_lvl(1'b0);
        tick(6);
    endtask

    task automatic do_read(bit [1:0] mode, bit exp, logic [15:0] d, string tag);
        mem_word = d;
        if (exp) expect_item(K_RD, '0, tag);
        case (mode)
            2'b00: begin dma_dack = dack_lvl(1'b1); dma_rd_n = 1'b0; end
            2'b01: dma_dack = dack_lvl(1'b1);
            2'b10: begin dma_sel = 1'b1; dma_rd_n = 1'b0; end
            default: begin dma_dack = dack_lvl(1'b1); dma_rd_n = 1'b0; dma_sel = 1'b1; end
        endcase
        tick(6);
        dma_rd_n = 1'b1;
        dma_sel = 1'b0;
        dma_dack = dack_lvl(1'b0);
        tick(8);
    endtask

    task automatic do_write(bit [1:0] mode, bit exp, bit tc, logic [15:0] d, string tag);
        dma_wdata = d;
        dma_tc = tc;
        if (exp) expect_item(tc ? K_WRC : K_WR, d, tag);
        case (mode)
            2'b00: begin dma_dack = dack_lvl(1'b1); dma_wr_n = 1'b0; end
            2'b01: dma_dack = dack_lvl(1'b1);
            2'b10: begin dma_sel = 1'b1; dma_wr_n = 1'b0; end
            default: begin dma_dack = dack_lvl(1'b1); dma_wr_n = 1'b0; dma_sel = 1'b1; end
        endcase
        tick(6);
        dma_wr_n = 1'b1;
        if (mode == 2'b01) dma_dack = dack_lvl(1'b0);
        tick(3);
        dma_sel = 1'b0;
        dma_dack = dack_lvl(1'b0);
        tick(8);
        dma_tc = 1'b0;
        tick(2);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int r0, w0;
        tick(5);
        rst_n = 1'b1;
        tick(1);
        // R12 reset state
        check(dma_dreq == 1'b1, "R12 request idle after reset", dma_dreq, 1);
        check(ctrl_rdata == '0, "R12 control reads zero", ctrl_rdata, 0);
        check({buf_rd_en, buf_wr_en, buf_commit, rd_ptr_clr, wr_ptr_clr} == '0,
              "R12 no pulses after reset",
              {buf_rd_en, buf_wr_en, buf_commit, rd_ptr_clr, wr_ptr_clr}, 0);

        // R1 per-transfer request, mode 00, OUT endpoint
        buf_ready = 1'b1;
        tick(4);
        check(dma_dreq == dreq_lvl(1'b1), "R1 request active when ready", dma_dreq, dreq_lvl(1'b1));
        mem_word = 16'hA5C3;
        expect_item(K_RD, '0, "R3 mode 00 read enable");
        dma_dack = dack_lvl(1'b1);
        dma_rd_n = 1'b0;
        tick(5);
        check(dma_dreq == dreq_lvl(1'b0), "R1 request drops during access", dma_dreq, dreq_lvl(1'b0));
        dma_rd_n = 1'b1;
        dma_dack = dack_lvl(1'b0);
        tick(6);
        check(dma_dreq == dreq_lvl(1'b1), "R1 request returns after access", dma_dreq, dreq_lvl(1'b1));
        check(dma_rdata == 16'hA5C3, "R11 read data from buffer", dma_rdata, 16'hA5C3);

        // R7 write on OUT endpoint is discarded
        w0 = wr_seen;
        do_write(2'b00, 1'b0, 1'b0, 16'h5555, "R7 blocked write");
        check(wr_seen == w0, "R7 OUT write produces no enable", wr_seen - w0, 0);

        // R3 mode 00 writes on IN endpoint, R8 with TC
        ep_is_in = 1'b1;
        do_write(2'b00, 1'b1, 1'b0, 16'h1234, "R3 mode 00 write data");
        do_write(2'b00, 1'b1, 1'b1, 16'h0BAD, "R8 TC write commits");
        r0 = rd_seen;
        do_read(2'b00, 1'b0, 16'h9999, "R7 blocked read");
        check(rd_seen == r0, "R7 IN read produces no enable", rd_seen - r0, 0);
        check(dma_rdata == '0, "R7 IN read returns zero", dma_rdata, 0);

        // R4 mode 01: acknowledge only
        set_ctrl(1'b0, 2'b01, 1'b0, 1'b0, 1'b0);
        do_write(2'b01, 1'b1, 1'b0, 16'hBEEF, "R4 mode 01 write on ack end");
        w0 = wr_seen;
        dma_wr_n = 1'b0; tick(6); dma_wr_n = 1'b1; tick(8);
        check(wr_seen == w0, "R4 WR ignored without ack", wr_seen - w0, 0);
        ep_is_in = 1'b0;
        tick(2);
        do_read(2'b01, 1'b1, 16'h0F0F, "R4 mode 01 read");
        check(dma_rdata == 16'h0F0F, "R4 mode 01 read data", dma_rdata, 16'h0F0F);

        // R5 mode 10: select replaces acknowledge
        set_ctrl(1'b0, 2'b10, 1'b0, 1'b0, 1'b0);
        r0 = rd_seen;
        dma_dack = dack_lvl(1'b1); dma_rd_n = 1'b0; tick(6);
        dma_rd_n = 1'b1; dma_dack = dack_lvl(1'b0); tick(8);
        check(rd_seen == r0, "R5 ack without select ignored", rd_seen - r0, 0);
        do_read(2'b10, 1'b1, 16'h6A6A, "R5 mode 10 read");
        check(dma_rdata == 16'h6A6A, "R5 mode 10 read data", dma_rdata, 16'h6A6A);
        ep_is_in = 1'b1;
        tick(2);
        do_write(2'b10, 1'b1, 1'b0, 16'h7E81, "R5 mode 10 write");

        // R6 reserved mode ignores everything
        set_ctrl(1'b0, 2'b11, 1'b0, 1'b0, 1'b0);
        r0 = rd_seen;
        w0 = wr_seen;
        do_write(2'b11, 1'b0, 1'b0, 16'h1111, "R6 reserved write");
        do_write(2'b01, 1'b0, 1'b0, 16'h2222, "R6 reserved ack write");
        ep_is_in = 1'b0;
        tick(2);
        do_read(2'b11, 1'b0, 16'h3333, "R6 reserved read");
        check(rd_seen == r0 && wr_seen == w0, "R6 reserved mode no enables",
              (rd_seen - r0) + (wr_seen - w0), 0);

        // R10 both polarities active high
        set_ctrl(1'b0, 2'b00, 1'b0, 1'b1, 1'b1);
        check(dma_dreq == 1'b1, "R10 request active high", dma_dreq, 1);
        do_read(2'b00, 1'b1, 16'h3C3C, "R10 high ack read");
        check(dma_rdata == 16'h3C3C, "R10 high ack read data", dma_rdata, 16'h3C3C);
        check(ctrl_rdata == 6'b000011, "R10 polarity bits read back", ctrl_rdata, 6'b000011);

        // R2 whole-buffer request, OUT endpoint
        buf_ready = 1'b0;
        set_ctrl(1'b1, 2'b00, 1'b0, 1'b0, 1'b0);
        fill_level = 10'd4;
        buf_ready = 1'b1;
        tick(4);
        check(dma_dreq == dreq_lvl(1'b1), "R2 burst request on ready rise", dma_dreq, dreq_lvl(1'b1));
        mem_word = 16'h4242;
        expect_item(K_RD, '0, "R2 burst read");
        dma_dack = dack_lvl(1'b1); dma_rd_n = 1'b0; tick(5);
        check(dma_dreq == dreq_lvl(1'b1), "R2 burst holds during access", dma_dreq, dreq_lvl(1'b1));
        dma_rd_n = 1'b1; dma_dack = dack_lvl(1'b0); tick(8);
        check(dma_dreq == dreq_lvl(1'b1), "R2 burst holds between accesses", dma_dreq, dreq_lvl(1'b1));
        fill_level = '0;
        tick(4);
        check(dma_dreq == dreq_lvl(1'b0), "R2 burst ends at empty", dma_dreq, dreq_lvl(1'b0));
        fill_level = 10'd4;
        tick(4);
        check(dma_dreq == dreq_lvl(1'b0), "R2 no re-arm without ready edge", dma_dreq, dreq_lvl(1'b0));

        // R2 IN endpoint full boundary, R8 TC closes the burst
        buf_ready = 1'b0;
        ep_is_in = 1'b1;
        fill_level = 10'd10;
        tick(2);
        buf_ready = 1'b1;
        tick(4);
        check(dma_dreq == dreq_lvl(1'b1), "R2 IN burst request", dma_dreq, dreq_lvl(1'b1));
        fill_level = LEVEL_W'(BUF_WORDS);
        tick(4);
        check(dma_dreq == dreq_lvl(1'b0), "R2 burst ends at full", dma_dreq, dreq_lvl(1'b0));
        buf_ready = 1'b0;
        fill_level = 10'd10;
        tick(2);
        buf_ready = 1'b1;
        tick(4);
        do_write(2'b00, 1'b1, 1'b1, 16'hC0DE, "R8 burst TC write commits");
        check(dma_dreq == dreq_lvl(1'b0), "R8 TC ends burst request", dma_dreq, dreq_lvl(1'b0));

        // R9 rewind steering and read-back
        buf_ready = 1'b0;
        buf_valid = 1'b1;
        set_ctrl(1'b0, 2'b00, 1'b1, 1'b0, 1'b0);
        check(ctrl_rdata[2] == 1'b0, "R9 rewind reads back zero", ctrl_rdata[2], 0);
        buf_valid = 1'b0;
        set_ctrl(1'b0, 2'b00, 1'b1, 1'b0, 1'b0);

        tick(4);
        check(q_kind.size() == 0, "R11 every expected strobe seen", q_kind.size(), 0);
        done_flag = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule